// File: doc/BRIEF.md
# Five-level stacked-carrier sine-triangle gate generator

This block drives the gates of one phase leg of a five-level inverter. A single up/down phase counter produces four triangular carriers of equal frequency. Each carrier sits in its own band of the reference range, and the four bands are stacked from bottom to top. A signed reference sample is compared with every carrier on every clock. Each comparison gives the gate drive for one complementary switch pair, as a high-side signal and its inverse. No dead time is inserted between the two.

A two-bit arrangement input sets how the carriers line up in phase. In the first setting all four carriers move together. In the second, the two bands below zero run in antiphase to the two above. In the third, neighbouring bands run in antiphase to each other. In the fourth, each band leads the band below it by a quarter of a period. The half-period of the carriers is an input, so each pair switches once per carrier period. The setting is taken only at the top of the base carrier. A one-cycle strobe marks that instant for surrounding logic, for example to update the reference sample in step with the carrier.

Top module: `mlspwm_gen`

## Requirements
- R1: While `rst_n` is low, all `gate_hi`, `gate_lo` and `peak_stb` bits are 0. They stay 0 for the first two rising edges after `rst_n` rises, which is the synchronous release.
- R2: The base phase counter counts 0, 1, … 2H−1 and then wraps to 0, where H = `half_per` (H ≥ 2, held constant outside reset). `peak_stb` is high for exactly one cycle per period. It appears one edge after the phase equals H.
- R3: Band b (b = 0 bottom … 3 top) has carrier value t_b + (b−2)·H. Here t_b is a triangle of the band's shifted phase p: t = p for p ≤ H and t = 2H−p otherwise.
- R4: `gate_hi[k]` drives switch pair k+1, and pair 1 is fed by the top band (b = 3−k). On each active edge, `gate_hi[k]` registers (`ref_smp` ≥ carrier of band 3−k), compared as signed numbers. As a result, `gate_hi` is always a thermometer code that fills from the bottom band up.
- R5: Outside reset, `gate_lo` is the bitwise inverse of `gate_hi`, registered on the same edge.
- R6: Arrangement code 0: all bands use the base phase unshifted.
- R7: Arrangement code 1: bands 0 and 1 are shifted by H, which puts them in antiphase. Bands 2 and 3 are unshifted.
- R8: Arrangement code 2: bands 1 and 3 are shifted by H. Bands 0 and 2 are unshifted.
- R9: Arrangement code 3: band b is shifted by b·floor(H/2) counts, modulo 2H.
- R10: `mode_sel` is captured only on the edge where the phase equals H, and it takes effect from the next edge. A change at any other time has no effect on the gates until that capture. Reset selects code 0.
- R11: A reference at or above 2H sets all four `gate_hi` bits. A reference below −2H clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_per | input | CW | Carrier half-period H in clock cycles |
| mode_sel | input | 2 | Carrier arrangement code (0..3) |
| ref_smp | input | CW+3 | Signed reference sample in carrier units |
| gate_hi | output | 4 | High-side gate per switch pair, bit 0 = pair 1 (top band) |
| gate_lo | output | 4 | Complementary gate per switch pair |
| peak_stb | output | 1 | One-cycle strobe at the top of the base carrier |

## Verification
The bench targets arrangement changes made in the middle of a period. A design that applies `mode_sel` at once would bend the carriers partway through a ramp, and the expected gate stream would break before the next strobe. The half-period is run at both even and odd values in the quarter-shift setting. A design that rounds the quarter shift the wrong way, or wraps the shifted phase at the wrong count, would switch a band one cycle early or late. References are swept across band edges and past both ends of the range. This catches a strict comparison where a non-strict one is required, and a band order that is reversed between pairs. The cycles just after reset release catch a phase counter or strobe that is off by one edge.

// File: rtl/mlspwm_pkg.sv
package mlspwm_pkg;

  localparam int NBAND = 4;

  typedef enum logic [1:0] {
    DISP_INPHASE   = 2'd0,
    DISP_HALFSPLIT = 2'd1,
    DISP_ALTERNATE = 2'd2,
    DISP_QUARTER   = 2'd3
  } disp_e;

  // Which bands run half a period away from the base phase.
  function automatic logic band_mirrored(input disp_e m, input int b);
    case (m)
      DISP_HALFSPLIT: return (b < NBAND / 2);
      DISP_ALTERNATE: return ((b % 2) == 1);
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mlspwm_phase_gen.sv
module mlspwm_phase_gen
  import mlspwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [CW-1:0] half_per,
  input  disp_e         mode_in,
  output logic [CW:0]   ph,
  output disp_e         mode_q,
  output logic          peak_q
);

  localparam int SW = CW + 2;

  logic [SW-1:0] two_h;
  logic [SW-1:0] ph_inc;
  logic          at_peak;
  logic [CW:0]   ph_nxt;
  disp_e         mode_nxt;

  always_comb begin
    two_h    = {1'b0, half_per, 1'b0};
    ph_inc   = {1'b0, ph} + 1'b1;
    at_peak  = (ph == {1'b0, half_per});
    ph_nxt   = (ph_inc >= two_h) ? '0 : ph_inc[CW:0];
    mode_nxt = at_peak ? mode_in : mode_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph     <= '0;
      mode_q <= DISP_INPHASE;
      peak_q <= 1'b0;
    end else begin
      ph     <= ph_nxt;
      mode_q <= mode_nxt;
      peak_q <= at_peak;
    end
  end

  // R10: the arrangement only moves on the peak edge
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph != {1'b0, half_per}) |=> $stable(mode_q));

  // R2: a strobe never lasts two cycles
  a_r2_peak_single: assert property (@(posedge clk) disable iff (!rst_ni)
    peak_q |=> !peak_q);

  // R2: the phase either advances by one or wraps to zero
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_ni |=> ((ph == 0) || (ph == $past(ph) + 1'b1)));

endmodule

// File: rtl/mlspwm_band.sv
module mlspwm_band
  import mlspwm_pkg::*;
#(
  parameter int CW   = 8,
  parameter int BAND = 0
) (
  input  logic [CW:0]          ph,
  input  logic [CW-1:0]        half_per,
  input  disp_e                mode,
  output logic signed [CW+2:0] carrier
);

  localparam int SW = CW + 2;
  localparam int RW = CW + 3;

  logic [SW-1:0]        hh;
  logic [SW-1:0]        two_h;
  logic [SW-1:0]        shift;
  logic [SW-1:0]        psum;
  logic [SW-1:0]        pwrap;
  logic [SW-1:0]        tri_v;
  logic signed [RW-1:0] hs;
  logic signed [RW-1:0] ofs;

  always_comb begin
    hh    = SW'(half_per);
    two_h = hh << 1;
    if (mode == DISP_QUARTER)
      shift = SW'(BAND) * (hh >> 1);
    else if (band_mirrored(mode, BAND))
      shift = hh;
    else
      shift = '0;
    psum  = SW'(ph) + shift;
    pwrap = (psum >= two_h) ? (psum - two_h) : psum;
    tri_v = (pwrap <= hh) ? pwrap : (two_h - pwrap);
    hs    = signed'(RW'(half_per));
    ofs   = signed'(RW'(BAND - NBAND / 2)) * hs;
    carrier = signed'(RW'(tri_v)) + ofs;
  end

endmodule

// File: rtl/mlspwm_pair_cmp.sv
module mlspwm_pair_cmp #(
  parameter int RW = 11
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic signed [RW-1:0] ref_smp,
  input  logic signed [RW-1:0] carrier,
  output logic                 gate_hi,
  output logic                 gate_lo
);

  logic hi_nxt;
  logic lo_nxt;

  always_comb begin
    hi_nxt = (ref_smp >= carrier);
    lo_nxt = ~hi_nxt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= hi_nxt;
      gate_lo <= lo_nxt;
    end
  end

  // R5: once running, the two sides of the pair never agree
  a_r5_complement: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_ni |=> (gate_lo == !gate_hi));

endmodule

// File: rtl/mlspwm_gen.sv
module mlspwm_gen
  import mlspwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      half_per,
  input  logic [1:0]         mode_sel,
  input  logic signed [CW+2:0] ref_smp,
  output logic [NBAND-1:0]   gate_hi,
  output logic [NBAND-1:0]   gate_lo,
  output logic               peak_stb
);

  localparam int RW = CW + 3;

  logic [1:0]           rst_sync;
  logic                 rst_i;
  logic [CW:0]          ph;
  disp_e                mode_q;
  logic signed [RW-1:0] carr [NBAND];
  logic signed [RW-1:0] hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  always_comb begin
    rst_i = rst_sync[1];
    hs    = signed'(RW'(half_per));
  end

  mlspwm_phase_gen #(.CW(CW)) u_phase (
    .clk     (clk),
    .rst_ni  (rst_i),
    .half_per(half_per),
    .mode_in (disp_e'(mode_sel)),
    .ph      (ph),
    .mode_q  (mode_q),
    .peak_q  (peak_stb)
  );

  for (genvar b = 0; b < NBAND; b++) begin : g_band
    mlspwm_band #(.CW(CW), .BAND(b)) u_band (
      .ph      (ph),
      .half_per(half_per),
      .mode    (mode_q),
      .carrier (carr[b])
    );

    // Pair k+1 takes band NBAND-1-k, so pair 1 sits at the top.
    mlspwm_pair_cmp #(.RW(RW)) u_cmp (
      .clk    (clk),
      .rst_ni (rst_i),
      .ref_smp(ref_smp),
      .carrier(carr[b]),
      .gate_hi(gate_hi[NBAND-1-b]),
      .gate_lo(gate_lo[NBAND-1-b])
    );

    // R3: each carrier stays inside its own band
    a_r3_band_range: assert property (@(posedge clk) disable iff (!rst_i)
      (carr[b] >= signed'(RW'(b - NBAND / 2)) * hs) &&
      (carr[b] <= signed'(RW'(b + 1 - NBAND / 2)) * hs));
  end

  // R4: stacked bands give a thermometer code, filling from the bottom pair
  a_r4_thermometer: assert property (@(posedge clk) disable iff (!rst_i)
    (!gate_hi[0] || gate_hi[1]) && (!gate_hi[1] || gate_hi[2]) &&
    (!gate_hi[2] || gate_hi[3]));

  // R6: in-phase carriers sit exactly one band height apart
  a_r6_inphase_spacing: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q == DISP_INPHASE) |->
      ((carr[1] - carr[0] == hs) && (carr[3] - carr[2] == hs)));

  // R7: antiphase halves mirror one another about zero
  a_r7_halfsplit_mirror: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q == DISP_HALFSPLIT) |-> (carr[2] + carr[1] == 0));

  // R1: the strobe is silent while the internal reset holds
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_i |=> !peak_stb || rst_i);

endmodule

// File: tb/tb_mlspwm_gen.sv
`timescale 1ns/1ps
module tb_mlspwm_gen;

  localparam int CW = 8;
  localparam int RW = CW + 3;
  localparam int NP = 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [CW-1:0]        half_per;
  logic [1:0]           mode_sel;
  logic signed [RW-1:0] ref_smp;
  logic [NP-1:0]        gate_hi;
  logic [NP-1:0]        gate_lo;
  logic                 peak_stb;

  always #5 clk = ~clk;

  mlspwm_gen #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .half_per(half_per), .mode_sel(mode_sel),
    .ref_smp(ref_smp), .gate_hi(gate_hi), .gate_lo(gate_lo), .peak_stb(peak_stb)
  );

  typedef struct {
    logic [NP-1:0] hi;
    logic [NP-1:0] lo;
    logic          pk;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Band carrier from the requirement text (R3, R6..R9).
  function automatic int band_carrier(int b, int ph, int md, int h);
    int sh;
    int p;
    int t;
    if (md == 3) sh = b * (h / 2);
    else if ((md == 1 && b < 2) || (md == 2 && (b % 2) == 1)) sh = h;
    else sh = 0;
    p = (ph + sh) % (2 * h);
    t = (p <= h) ? p : 2 * h - p;
    return t + (b - 2) * h;
  endfunction

  // Driver side: predicts the registered outputs of every edge.
  int rel_m = 0;
  int ph_m = 0;
  int mode_m = 0;
  always @(posedge clk) begin
    exp_t e;
    int h;
    e.hi = '0; e.lo = '0; e.pk = 1'b0;
    if (!rst_n) begin
      rel_m = 0; ph_m = 0; mode_m = 0;
    end else if (rel_m < 2) begin
      rel_m++;
    end else begin
      h = int'(half_per);
      for (int k = 0; k < NP; k++)
        e.hi[k] = (int'(ref_smp) >= band_carrier(NP - 1 - k, ph_m, mode_m, h));
      e.lo = ~e.hi;
      e.pk = (ph_m == h);
      if (ph_m == h) mode_m = int'(mode_sel);
      ph_m = (ph_m + 1 >= 2 * h) ? 0 : ph_m + 1;
    end
    sb_q.push_back(e);
  end

  // Monitor side: compares away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0 && !done) begin
      e = sb_q.pop_front();
      checks++;
      if (gate_hi !== e.hi || gate_lo !== e.lo || peak_stb !== e.pk) begin
        fails++;
        $display("FAIL %s: hi=%b lo=%b pk=%b expected hi=%b lo=%b pk=%b",
                 cur_req, gate_hi, gate_lo, peak_stb, e.hi, e.lo, e.pk);
      end
    end
  end

  task automatic sweep(int n, int stride);
    int h;
    h = int'(half_per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_smp = RW'(((i * stride) % (4 * h + 7)) - (2 * h + 3));
    end
  endtask

  task automatic restart(int h, int md);
    @(negedge clk);
    #1 rst_n = 1'b0;
    half_per = CW'(h);
    mode_sel = 2'(md);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; half_per = CW'(8); mode_sel = 2'd0; ref_smp = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (gate_hi !== '0 || gate_lo !== '0 || peak_stb !== 1'b0) begin
      fails++;
      $display("FAIL R1: hi=%b lo=%b pk=%b expected all zero", gate_hi, gate_lo, peak_stb);
    end
    rst_n = 1'b1;

    cur_req = "R6 in-phase with R2 R3 R4 R5";
    sweep(600, 37);
    sweep(400, 1);
    cur_req = "R7 halfsplit";
    mode_sel = 2'd1;
    sweep(600, 37);
    cur_req = "R8 alternate";
    mode_sel = 2'd2;
    sweep(600, 29);
    cur_req = "R9 quarter H=8";
    mode_sel = 2'd3;
    sweep(600, 31);

    cur_req = "R10 mid-period changes";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i % 5 == 0) mode_sel = 2'((i / 5) % 4);
      ref_smp = RW'(((i * 13) % 39) - 19);
    end

    cur_req = "R11 reference beyond range";
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      ref_smp = (i < 40) ? RW'(1000) : RW'(-1000);
    end

    cur_req = "R1 restart";
    restart(7, 3);
    cur_req = "R9 quarter H=7";
    sweep(30, 11);
    mode_sel = 2'd3;
    sweep(500, 17);
    cur_req = "R7 halfsplit H=7";
    mode_sel = 2'd1;
    sweep(300, 23);

    cur_req = "R1 restart";
    restart(6, 0);
    cur_req = "R9 quarter H=6 and R10";
    mode_sel = 2'd3;
    sweep(400, 19);
    cur_req = "R8 alternate H=6";
    mode_sel = 2'd2;
    sweep(300, 7);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: %s run did not complete, expected finish", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule